// File: doc/BRIEF.md
# Panel Power Sequencer

This block orders the three switched resources of a flat-panel display: the panel logic supply, the drive of the video interface signals, and the backlight lamp. A power request brings them up in the order supply, signals, lamp, and its removal takes them down in the reverse order. Each gap is a minimum number of millisecond ticks, so the panel never sees its interface driven without supply. The lamp never lights before the picture is valid, and it is always dark well before the picture stops.

Time is measured with a one-cycle `ms_tick` pulse, which an external prescaler produces from the system clock. Every delay is a parameter counted in these ticks. A tick is counted when it is sampled on a clock edge after the edge that entered the current state. Once the supply has been removed, it cannot be re-applied until a minimum off time has passed. That off time is also enforced after reset. If the supply fails to report good within a ramp limit, the supply enable is dropped and a sticky fault output is raised. The fault clears at the next power attempt. If the request is withdrawn part of the way up, the block begins the power-down from wherever it is, and every minimum gap still applies.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `vdd_en`, `sig_en`, `lamp_en` and `fault` are all low.
- R2: `vdd_en` rises only on the clock after `pwr_req` is seen high and at least `OFF_MIN_MS` ticks have elapsed since `vdd_en` last fell, or since reset.
- R3: `sig_en` rises on the clock after `vdd_good` is sampled high while `vdd_en` is high, `sig_en` is low and `pwr_req` is held. It never rises otherwise.
- R4: If `vdd_good` has not been seen after `RAMP_MAX_MS` ticks of `vdd_en`, then `vdd_en` drops and `fault` goes high on the same clock. `fault` stays high until the next rise of `vdd_en`, which clears it.
- R5: `lamp_en` rises only after `sig_en` has been high for `LAMP_ON_MS` ticks with `pwr_req` held.
- R6: When `pwr_req` falls while the lamp is on, `lamp_en` falls on the next clock. `sig_en` then stays high for `LAMP_OFF_MS` further ticks. A request that returns during this wait has no effect, and the lamp stays off until the full power-down and off time are complete.
- R7: On every power-down, `sig_en` is low for at least one clock before `vdd_en` falls.
- R8: A request dropped while the supply is ramping turns `vdd_en` off on the next clock and never enables the signals. A request dropped after the signals are on but before the lamp turns on clears `sig_en` on the next clock and `vdd_en` one clock later, and the lamp never turns on.
- R9: At all times, `lamp_en` high implies `sig_en` high, and `sig_en` high implies `vdd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_req | input | 1 | High requests the panel powered and lit |
| vdd_good | input | 1 | Panel supply has reached its good level |
| vdd_en | output | 1 | Panel logic supply enable |
| sig_en | output | 1 | Interface signal drive enable; low forces the signals low |
| lamp_en | output | 1 | Backlight lamp enable |
| fault | output | 1 | Supply ramp timeout seen; sticky until the next attempt |

## Verification
The assertions assume that `ms_tick` is a synchronous pulse no longer than one cycle per count. They also assume that `vdd_good` only goes high while `vdd_en` is driven and falls when the supply is removed. The stimulus models the supply so that it follows this: `vdd_good` is held low whenever `vdd_en` is low, and it rises after a random delay. Sometimes that delay is beyond the ramp limit, and sometimes the supply is never allowed to come good, so that the timeout is reached. Ticks arrive at random spacing. The request toggles at random, together with directed drops in each phase of the power-up and a re-request during the lamp-off wait.

// File: rtl/panel_power_seq.sv
module panel_power_seq #(
  parameter int OFF_MIN_MS  = 100,
  parameter int RAMP_MAX_MS = 10,
  parameter int LAMP_ON_MS  = 180,
  parameter int LAMP_OFF_MS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pwr_req,
  input  logic vdd_good,
  output logic vdd_en,
  output logic sig_en,
  output logic lamp_en,
  output logic fault
);

  localparam int MAX_A = (OFF_MIN_MS > RAMP_MAX_MS) ? OFF_MIN_MS : RAMP_MAX_MS;
  localparam int MAX_B = (LAMP_ON_MS > LAMP_OFF_MS) ? LAMP_ON_MS : LAMP_OFF_MS;
  localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXD + 1);
  localparam logic [CW-1:0] CMAX   = CW'(MAXD);
  localparam logic [CW-1:0] T_OFF  = CW'(OFF_MIN_MS);
  localparam logic [CW-1:0] T_RAMP = CW'(RAMP_MAX_MS);
  localparam logic [CW-1:0] T_LON  = CW'(LAMP_ON_MS);
  localparam logic [CW-1:0] T_LOFF = CW'(LAMP_OFF_MS);

  typedef enum logic [2:0] {
    ST_DARK, ST_RAMP, ST_VIDEO, ST_LIT, ST_DIM_WAIT, ST_UNDRIVE
  } seq_t;

  seq_t          st, st_nx;
  logic [CW-1:0] cnt;
  logic          timeout;

  always_comb begin
    st_nx   = st;
    timeout = 1'b0;
    unique case (st)
      ST_DARK:     if (pwr_req && cnt >= T_OFF) st_nx = ST_RAMP;
      ST_RAMP: begin
        if (!pwr_req)              st_nx = ST_DARK;
        else if (vdd_good)         st_nx = ST_VIDEO;
        else if (cnt >= T_RAMP) begin
          st_nx   = ST_DARK;
          timeout = 1'b1;
        end
      end
      ST_VIDEO: begin
        if (!pwr_req)              st_nx = ST_UNDRIVE;
        else if (cnt >= T_LON)     st_nx = ST_LIT;
      end
      ST_LIT:      if (!pwr_req)      st_nx = ST_DIM_WAIT;
      ST_DIM_WAIT: if (cnt >= T_LOFF) st_nx = ST_UNDRIVE;
      ST_UNDRIVE:  st_nx = ST_DARK;
      default:     st_nx = ST_DARK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_DARK;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st)                cnt <= '0;
      else if (ms_tick && cnt < CMAX) cnt <= cnt + 1'b1;
      if (timeout)                               fault <= 1'b1;
      else if (st == ST_DARK && st_nx == ST_RAMP) fault <= 1'b0;
    end
  end

  assign vdd_en  = (st != ST_DARK);
  assign sig_en  = (st == ST_VIDEO) || (st == ST_LIT) || (st == ST_DIM_WAIT);
  assign lamp_en = (st == ST_LIT);

  logic [CW-1:0] off_age, sig_age, dark_gap;
  logic          lamp_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_age   <= '0;
      sig_age   <= '0;
      dark_gap  <= '0;
      lamp_seen <= 1'b0;
    end else begin
      if (vdd_en)                         off_age <= '0;
      else if (ms_tick && off_age < CMAX) off_age <= off_age + 1'b1;
      if (!sig_en)                        sig_age <= '0;
      else if (ms_tick && sig_age < CMAX) sig_age <= sig_age + 1'b1;
      if (lamp_en)                          dark_gap <= '0;
      else if (ms_tick && dark_gap < CMAX)  dark_gap <= dark_gap + 1'b1;
      if (lamp_en)      lamp_seen <= 1'b1;
      else if (!vdd_en) lamp_seen <= 1'b0;
    end
  end

  a_r2_off_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vdd_en) |-> (off_age >= T_OFF) && $past(pwr_req));

  a_r3_sig_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_en) |-> $past(vdd_good) && $past(vdd_en) && $past(pwr_req));

  a_r4_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> !vdd_en && $past(vdd_en) && !$past(vdd_good));

  a_r5_lamp_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lamp_en) |-> sig_age >= T_LON);

  a_r6_lamp_lead: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sig_en) && lamp_seen) |-> dark_gap >= T_LOFF);

  a_r7_sig_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> !$past(sig_en));

endmodule

// File: tb/sim_panel_power_seq.sv
module sim_panel_power_seq;
  localparam int P_OFF = 6, P_RAMP = 5, P_LON = 9, P_LOFF = 7;
  localparam int P_MAX = 9;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, pwr_req = 1'b0, vdd_good = 1'b0;
  logic vdd_en, sig_en, lamp_en, fault;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0, good_allow = 1'b1;
  int   good_max = 14, gwait = 0;

  always #4 clk = ~clk;

  panel_power_seq #(.OFF_MIN_MS(P_OFF), .RAMP_MAX_MS(P_RAMP),
                    .LAMP_ON_MS(P_LON), .LAMP_OFF_MS(P_LOFF)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_req(pwr_req),
    .vdd_good(vdd_good), .vdd_en(vdd_en), .sig_en(sig_en),
    .lamp_en(lamp_en), .fault(fault));

  // reference: 0 dark, 1 ramp, 2 video, 3 lit, 4 dim wait, 5 undrive
  int m_st = 0, m_cnt = 0;
  bit m_fault = 1'b0;

  function automatic int ref_next(int s, int c, bit rq, bit gd);
    case (s)
      0: return (rq && c >= P_OFF) ? 1 : 0;
      1: return !rq ? 0 : gd ? 2 : (c >= P_RAMP) ? 0 : 1;
      2: return !rq ? 5 : (c >= P_LON) ? 3 : 2;
      3: return !rq ? 4 : 3;
      4: return (c >= P_LOFF) ? 5 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0: return "R2";
      1: return "R4";
      2: return "R3";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [3:0] exp_out(int s, bit f);
    return {s != 0, s == 2 || s == 3 || s == 4, s == 3, f};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_fault = 1'b0;
    end else begin
      int nx;
      nx = ref_next(m_st, m_cnt, pwr_req, vdd_good);
      if (m_st == 1 && nx == 0 && pwr_req) m_fault = 1'b1;
      else if (m_st == 0 && nx == 1)       m_fault = 1'b0;
      if (nx != m_st)                      m_cnt = 0;
      else if (ms_tick && m_cnt < P_MAX)   m_cnt = m_cnt + 1;
      m_st = nx;
    end
  end

  task automatic check(bit ok, string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [3:0] a, e;
    a = {vdd_en, sig_en, lamp_en, fault};
    e = exp_out(m_st, m_fault);
    check(a == e, tag_of(m_st), a, e);
    check(!(lamp_en && !sig_en) && !(sig_en && !vdd_en), "R9", a, 4'b0);
  end

  always @(negedge clk) begin
    ms_tick <= ($urandom_range(0, 2) == 0);
    if (!vdd_en) begin
      vdd_good <= 1'b0;
      gwait    = $urandom_range(0, good_max);
    end else if (gwait == 0) begin
      if (good_allow) vdd_good <= 1'b1;
    end else gwait--;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_for(ref logic s, input logic v);
    for (int i = 0; i < 3000 && s !== v; i++) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finish");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    cyc(3);
    check({vdd_en, sig_en, lamp_en, fault} == 4'b0, "R1",
          {vdd_en, sig_en, lamp_en, fault}, 4'b0);
    rst_n = 1'b1;
    cyc(2);
    check({vdd_en, sig_en, lamp_en, fault} == 4'b0, "R1",
          {vdd_en, sig_en, lamp_en, fault}, 4'b0);

    // R6: full power-up, drop while lit, re-request during the wait
    pwr_req = 1'b1;
    wait_for(lamp_en, 1'b1);
    pwr_req = 1'b0;
    cyc(1);
    check(!lamp_en && sig_en, "R6", {vdd_en, sig_en, lamp_en, fault}, 4'b1100);
    pwr_req = 1'b1;
    for (int i = 0; i < 500 && vdd_en; i++) begin
      check(!lamp_en, "R6", {3'b0, lamp_en}, 4'b0);
      cyc(1);
    end

    // R8: drop right after the signals come on
    wait_for(sig_en, 1'b1);
    pwr_req = 1'b0;
    cyc(1);
    check(!sig_en && vdd_en && !lamp_en, "R8", {vdd_en, sig_en, lamp_en, fault}, 4'b1000);
    cyc(1);
    check(!vdd_en && !lamp_en, "R8", {vdd_en, sig_en, lamp_en, fault}, 4'b0);

    // R8: drop during the supply ramp
    good_allow = 1'b0;
    pwr_req = 1'b1;
    wait_for(vdd_en, 1'b1);
    pwr_req = 1'b0;
    cyc(1);
    check(!vdd_en && !sig_en, "R8", {vdd_en, sig_en, lamp_en, fault}, 4'b0);

    // R4: supply never reports good
    pwr_req = 1'b1;
    wait_for(fault, 1'b1);
    check(fault && !vdd_en, "R4", {vdd_en, sig_en, lamp_en, fault}, 4'b0001);
    good_allow = 1'b1;
    good_max = 3;
    wait_for(vdd_en, 1'b1);
    check(vdd_en && !fault, "R4", {vdd_en, sig_en, lamp_en, fault}, 4'b1000);
    good_max = 14;

    // random request patterns
    for (int k = 0; k < 400; k++) begin
      pwr_req = ($urandom_range(0, 3) != 0);
      cyc(pwr_req ? $urandom_range(1, 60) : $urandom_range(1, 25));
    end
    pwr_req = 1'b0;
    cyc(100);
    finish_up();
  end
endmodule